// File: doc/BRIEF.md
# Three-Phase Hall Commutation Gate Sequencer

This block turns three Hall sensor levels, spaced 120 electrical degrees apart, and a rotation-direction input into six gate commands for a three-phase half-bridge inverter. Each phase has one high-side gate and one low-side gate. Each valid Hall code selects one phase as the source (its high side) and one phase as the sink (its low side). The third phase floats.

A chopper source-enable input controls the selected pair. While it is high, the pair conducts. While it is low, the winding current recirculates, and a decay-mode input picks the path:
- **Slow decay** turns on the low sides of both involved phases, which gives synchronous rectification.
- **Fast decay** turns on the complementary switches of those two phases.

Several inputs override normal commutation. A brake request shorts the windings through all low sides. A fault coast input turns every gate off. A high-side inhibit input blocks only the high sides. A hold-in-reset input overrides all of these. On the rising edge of the hold, the block latches a brake-or-coast choice and applies it for as long as the hold lasts.

Each phase owns a dead-time down-counter. The counter loads from a programmable cycle count whenever the requested state of that phase changes. Both gates of that phase stay low until the counter reaches zero.

Top module: `hall_commutator`

## Requirements
- R1: With `dir_fwd`=1 and the Hall code written as {H1,H2,H3} = `hall[2:0]`, the source/sink phases are as follows (phase A is bit 0, B is bit 1, C is bit 2 of each gate bus): 101→A/C, 100→B/C, 110→B/A, 010→C/A, 011→C/B, 001→A/B.
- R2: With `dir_fwd`=0, each code swaps source and sink relative to R1: 101→C/A, 100→C/B, 110→A/B, 010→A/C, 011→B/C, 001→B/A.
- R3: With `chop_en`=1, the source phase high gate and the sink phase low gate are on, and every other gate is off.
- R4: With `chop_en`=0 and `slow_decay`=1, the low gates of both the source and sink phases are on, and all high gates are off.
- R5: With `chop_en`=0 and `slow_decay`=0, the source phase low gate and the sink phase high gate are on, and every other gate is off.
- R6: Hall codes 000 and 111 turn all six gates off.
- R7: `brake_req`=1 turns on all three low gates and turns off all high gates, whatever the Hall code and chopper state.
- R8: `coast_req`=1 turns all gates off and takes priority over `brake_req`.
- R9: `hs_inhibit`=1 forces every high gate off and leaves the low gates of normal operation as they are.
- R10: While `hold_rst`=1, the block ignores `brake_req` and `coast_req`. It applies the value that `brake_on_hold` had in the cycle `hold_rst` rose: 1 turns all low gates on, 0 turns all gates off. Changes to `brake_on_hold` during the hold have no effect.
- R11: When the requested state of a phase changes and the change is registered at a clock edge, both gates of that phase stay low for `dead_cycles` further edges. The new state appears after edge `dead_cycles`+1, counted from the edge that registered the change. With `dead_cycles`=0, the new state appears one clock after the input change. A phase whose request does not change keeps its gates.
- R12: The high and low gates of one phase are never on together.
- R13: While `rst_n` is low, all gates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall | input | 3 | Hall levels {H1,H2,H3} |
| dir_fwd | input | 1 | Rotation direction select |
| chop_en | input | 1 | Chopper source-enable (PWM combined with current limit) |
| slow_decay | input | 1 | 1 selects slow decay, 0 selects fast decay |
| brake_req | input | 1 | Dynamic brake request |
| hold_rst | input | 1 | Hold-in-reset, overrides brake and coast |
| brake_on_hold | input | 1 | Brake (1) or coast (0) choice latched when the hold rises |
| coast_req | input | 1 | Fault coast, all gates off |
| hs_inhibit | input | 1 | Fault high-side block |
| dead_cycles | input | DT_W | Dead time in clock cycles |
| gate_hi | output | 3 | High-side gate commands, bit 0 = phase A |
| gate_lo | output | 3 | Low-side gate commands, bit 0 = phase A |

## Verification
Dead-time insertion and commutation can act in the same cycle. When a Hall step moves the source from one phase to another, one phase turns off and another turns on under its own counter, while the shared sink phase must keep conducting without a gap. The bench provokes this with a nonzero dead time and a step from code 101 to 100. It then judges at the exact edge counts that the outgoing and incoming phases stay dark, that the shared sink phase stays on throughout, and that the new high gate appears on the predicted edge. A second overlap, in which the hold-in-reset and a brake request are raised together, is judged by checking that the latched hold choice wins.

// File: rtl/hall_commutator.sv
module hall_commutator #(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      hall,
  input  logic            dir_fwd,
  input  logic            chop_en,
  input  logic            slow_decay,
  input  logic            brake_req,
  input  logic            hold_rst,
  input  logic            brake_on_hold,
  input  logic            coast_req,
  input  logic            hs_inhibit,
  input  logic [DT_W-1:0] dead_cycles,
  output logic [2:0]      gate_hi,
  output logic [2:0]      gate_lo
);

  localparam int NPH = 3;
  localparam logic [1:0] PH_OFF = 2'd0;
  localparam logic [1:0] PH_HI  = 2'd1;
  localparam logic [1:0] PH_LO  = 2'd2;

  logic [1:0] fwd_src, fwd_snk, src, snk;
  logic       code_ok;
  logic       hold_q, brk_latch, use_brk;
  logic [NPH-1:0][1:0] req;

  always_comb begin
    code_ok = 1'b1;
    fwd_src = 2'd0;
    fwd_snk = 2'd0;
    case (hall)
      3'b101: begin fwd_src = 2'd0; fwd_snk = 2'd2; end
      3'b100: begin fwd_src = 2'd1; fwd_snk = 2'd2; end
      3'b110: begin fwd_src = 2'd1; fwd_snk = 2'd0; end
      3'b010: begin fwd_src = 2'd2; fwd_snk = 2'd0; end
      3'b011: begin fwd_src = 2'd2; fwd_snk = 2'd1; end
      3'b001: begin fwd_src = 2'd0; fwd_snk = 2'd1; end
      default: code_ok = 1'b0;
    endcase
  end

  assign src = dir_fwd ? fwd_src : fwd_snk;
  assign snk = dir_fwd ? fwd_snk : fwd_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      brk_latch <= 1'b0;
    end else begin
      hold_q <= hold_rst;
      if (hold_rst && !hold_q) brk_latch <= brake_on_hold;
    end
  end

  assign use_brk = (hold_rst && !hold_q) ? brake_on_hold : brk_latch;

  always_comb begin
    for (int p = 0; p < NPH; p++) req[p] = PH_OFF;
    if (hold_rst) begin
      for (int p = 0; p < NPH; p++) req[p] = use_brk ? PH_LO : PH_OFF;
    end else if (coast_req) begin
      for (int p = 0; p < NPH; p++) req[p] = PH_OFF;
    end else if (brake_req) begin
      for (int p = 0; p < NPH; p++) req[p] = PH_LO;
    end else if (code_ok) begin
      if (chop_en) begin
        req[src] = PH_HI;
        req[snk] = PH_LO;
      end else if (slow_decay) begin
        req[src] = PH_LO;
        req[snk] = PH_LO;
      end else begin
        req[src] = PH_LO;
        req[snk] = PH_HI;
      end
    end
    if (hs_inhibit) begin
      for (int p = 0; p < NPH; p++)
        if (req[p] == PH_HI) req[p] = PH_OFF;
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [1:0]      tgt;
    logic [DT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tgt <= PH_OFF;
        cnt <= '0;
      end else if (req[p] != tgt) begin
        tgt <= req[p];
        cnt <= dead_cycles;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign gate_hi[p] = (cnt == '0) && (tgt == PH_HI);
    assign gate_lo[p] = (cnt == '0) && (tgt == PH_LO);

    // R12
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[p] && gate_lo[p]));

    // R11
    dead_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dead_cycles != '0) && $rose(gate_hi[p]) |-> !$past(gate_lo[p]));

    // R11
    dead_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dead_cycles != '0) && $rose(gate_lo[p]) |-> !$past(gate_hi[p]));

    // R7
    brake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brake_req && !hold_rst && !coast_req |=> tgt == PH_LO);

    // R8
    coast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coast_req && !hold_rst |=> tgt == PH_OFF);

    // R9
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_inhibit |=> tgt != PH_HI);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_rst |=> tgt != PH_HI);

    // R6
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_rst && !brake_req && (hall == 3'b000 || hall == 3'b111) |=> tgt == PH_OFF);
  end

endmodule

// File: tb/hall_commutator_tb.sv
module hall_commutator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DT_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic dir_fwd = 1'b1, chop_en = 1'b0, slow_decay = 1'b0, brake_req = 1'b0;
  logic hold_rst = 1'b0, brake_on_hold = 1'b0, coast_req = 1'b0, hs_inhibit = 1'b0;
  logic [DT_W-1:0] dead_cycles = '0;
  logic [2:0] gate_hi, gate_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {code, dir, source phase, sink phase}
  localparam logic [7:0] VEC [12] = '{
    8'b101_1_00_10, 8'b100_1_01_10, 8'b110_1_01_00,
    8'b010_1_10_00, 8'b011_1_10_01, 8'b001_1_00_01,
    8'b101_0_10_00, 8'b100_0_10_01, 8'b110_0_00_01,
    8'b010_0_00_10, 8'b011_0_01_10, 8'b001_0_01_00
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  hall_commutator #(.DT_W(DT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .hall(hall), .dir_fwd(dir_fwd),
    .chop_en(chop_en), .slow_decay(slow_decay), .brake_req(brake_req),
    .hold_rst(hold_rst), .brake_on_hold(brake_on_hold), .coast_req(coast_req),
    .hs_inhibit(hs_inhibit), .dead_cycles(dead_cycles),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [2:0] eh, input logic [2:0] el);
    checks++;
    if (gate_hi !== eh || gate_lo !== el) begin
      errors++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, gate_hi, gate_lo, eh, el);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] eh, el;
    @(negedge clk);
    @(negedge clk);
    check("R13 reset state", 3'b000, 3'b000);
    rst_n = 1'b1;
    step(2);
    check("R6 code 000 after reset", 3'b000, 3'b000);

    // table walk, zero dead time
    for (int i = 0; i < 12; i++) begin
      for (int m = 0; m < 3; m++) begin
        hall = VEC[i][7:5];
        dir_fwd = VEC[i][4];
        chop_en = (m == 0);
        slow_decay = (m == 1);
        step(1);
        eh = 3'b000;
        el = 3'b000;
        if (m == 0) begin
          eh[VEC[i][3:2]] = 1'b1;
          el[VEC[i][1:0]] = 1'b1;
        end else if (m == 1) begin
          el[VEC[i][3:2]] = 1'b1;
          el[VEC[i][1:0]] = 1'b1;
        end else begin
          el[VEC[i][3:2]] = 1'b1;
          eh[VEC[i][1:0]] = 1'b1;
        end
        check(VEC[i][4] ? (m == 0 ? "R1/R3" : m == 1 ? "R1/R4" : "R1/R5")
                        : (m == 0 ? "R2/R3" : m == 1 ? "R2/R4" : "R2/R5"), eh, el);
      end
    end

    dir_fwd = 1'b1; chop_en = 1'b1; slow_decay = 1'b0;
    hall = 3'b111; step(1);
    check("R6 code 111", 3'b000, 3'b000);
    hall = 3'b000; step(1);
    check("R6 code 000", 3'b000, 3'b000);

    hall = 3'b101; brake_req = 1'b1; step(1);
    check("R7 brake over chop", 3'b000, 3'b111);
    coast_req = 1'b1; step(1);
    check("R8 coast over brake", 3'b000, 3'b000);
    coast_req = 1'b0; brake_req = 1'b0; step(1);
    check("R3 resume after coast", 3'b001, 3'b100);

    hs_inhibit = 1'b1; step(1);
    check("R9 inhibit chop", 3'b000, 3'b100);
    chop_en = 1'b0; slow_decay = 1'b1; step(1);
    check("R9 inhibit slow decay lows kept", 3'b000, 3'b101);
    hs_inhibit = 1'b0; chop_en = 1'b1; slow_decay = 1'b0; step(1);

    hold_rst = 1'b1; brake_on_hold = 1'b1; step(1);
    check("R10 hold brake", 3'b000, 3'b111);
    brake_on_hold = 1'b0; step(1);
    check("R10 hold choice latched", 3'b000, 3'b111);
    hold_rst = 1'b0; step(1);
    check("R10 release", 3'b001, 3'b100);
    hold_rst = 1'b1; brake_req = 1'b1; step(1);
    check("R10 hold coast over brake", 3'b000, 3'b000);
    brake_on_hold = 1'b1; step(1);
    check("R10 late choice ignored", 3'b000, 3'b000);
    hold_rst = 1'b0; brake_req = 1'b0; brake_on_hold = 1'b0;

    // dead time
    dead_cycles = 10'd5;
    hall = 3'b000; step(10);
    check("R11 settled off", 3'b000, 3'b000);
    hall = 3'b101; step(5);
    check("R11 gap held", 3'b000, 3'b000);
    step(1);
    check("R11 on after dead time", 3'b001, 3'b100);
    hall = 3'b100; step(5);
    check("R11 commutation gap, sink kept", 3'b000, 3'b100);
    step(1);
    check("R11 new source on", 3'b010, 3'b100);
    chop_en = 1'b0; step(1);
    check("R12 fast decay transition dark", 3'b000, 3'b000);
    step(5);
    check("R5 fast decay after dead time", 3'b100, 3'b010);

    rst_n = 1'b0; #1;
    check("R13 async reset", 3'b000, 3'b000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule